// File: doc/BRIEF.md
# Opcode-Menu SPI Flash Sequencer

This block runs one complete SPI flash command per request, built from tables that software loads ahead of time. Software fills a menu of eight opcode bytes. Each menu entry has a 2-bit type that says whether a 24-bit address follows the opcode and which way the data moves. Software also loads two prefix opcodes, the flash address and a byte buffer. It then writes one control word. That word picks a menu entry, optionally asks for a prefix opcode to be sent first, enables a data phase of 1 to `BUF_BYTES` bytes, and starts the cycle.

The engine drives an SPI mode-0 bus. The prefix, when one is requested, goes out in its own chip-select frame. The main frame follows and carries the opcode, then the address (most significant byte first), then the data. Write types send bytes from the buffer. Read types put the bytes received on MISO into the buffer. A status word reports busy, done and error. A start that cannot be served sets the error and done flags and produces no bus activity.

Top module: `flash_seq_top`

## Requirements
- R1: Menu entry n is the byte at bits 8·(n mod 4) of register 0 for n below 4, and of register 1 otherwise. Control field index [2:0] selects the entry, and that byte is the first byte of the main frame.
- R2: Type field n sits at bits 2n+1:2n of register 2. Types 2 and 3 put the address in register 4 (bits 23:0) after the opcode, high byte first. Types 0 and 1 send no address.
- R3: Control bit 4 set sends a prefix in a separate frame before the main frame. That prefix is register 3 bits 15:8 when control bit 5 is set, and bits 7:0 otherwise. Chip select stays high for at least two SCK periods between the two frames.
- R4: Control bit 6 enables a data phase of (field [14:8] + 1) bytes. Write types (1, 3) send buffer byte k, which sits at data word k/4 (address 16 + k/4), bits 8·(k mod 4).
- R5: Read types (0, 2) send 0x00 during the data phase and store received byte k at buffer byte k. Buffer bytes beyond the count keep their value.
- R6: With control bit 6 clear, the frame ends after the opcode or the address, whatever the count field holds.
- R7: Status (register 6) bit 0 is busy during a cycle. Bit 1 (done) is set at the end of a cycle. Bit 2 (error) is set only together with done. Writing 1 to bit 1 or bit 2 clears that bit.
- R8: A start (control bit 7) written while busy sets error and done and does not disturb the transfer in progress.
- R9: A start with the data phase enabled and a count field of `BUF_BYTES` or more sets error and done, and chip select never goes low.
- R10: SCK idles low. MOSI is stable while SCK is high. SCK runs at 2·`DIV_HALF` clock periods per bit.
- R11: After reset, chip select is high, SCK is low and status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Word address of the register |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| spi_sck_o | output | 1 | SPI clock |
| spi_cs_no | output | 1 | SPI chip select, active low |
| spi_mosi_o | output | 1 | SPI data out |
| spi_miso_i | input | 1 | SPI data in |

## Verification
The hardest case to produce from the ports is a start that arrives while the engine is already shifting. The bench launches a long read and writes a second start a few cycles later, while the first transfer is still running. It then checks three things: the error flag is set while busy still reads 1, exactly one frame appears on the bus, and that frame holds the first command's bytes. The inter-frame gap after a prefix is also awkward to observe. A bus monitor measures the time chip select spends high between the two frames and compares it against the SCK period.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    TY_RD    = 2'd0,
    TY_WR    = 2'd1,
    TY_RD_A  = 2'd2,
    TY_WR_A  = 2'd3
  } op_type_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_GAP,
    ST_CMD,
    ST_ADR,
    ST_DAT
  } seq_state_e;

  // control-side register indices
  localparam logic [2:0] RG_MENU_LO = 3'd0;
  localparam logic [2:0] RG_MENU_HI = 3'd1;
  localparam logic [2:0] RG_TYPES   = 3'd2;
  localparam logic [2:0] RG_PREFIX  = 3'd3;
  localparam logic [2:0] RG_ADDR    = 3'd4;
  localparam logic [2:0] RG_CTRL    = 3'd5;
  localparam logic [2:0] RG_STATUS  = 3'd6;

  // control word bits
  localparam int CB_PRE_EN  = 4;
  localparam int CB_PRE_SEL = 5;
  localparam int CB_DATA_EN = 6;
  localparam int CB_GO      = 7;
  localparam int CB_CNT_LSB = 8;

  // status bits
  localparam int SB_BUSY = 0;
  localparam int SB_DONE = 1;
  localparam int SB_ERR  = 2;

endpackage

// File: rtl/flash_seq_clkdiv.sv
module flash_seq_clkdiv #(
  parameter  int DIV_HALF = 2,
  localparam int CW       = $clog2(DIV_HALF + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(DIV_HALF - 1));
  assign tick_o = en_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/flash_seq_shift.sv
module flash_seq_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);

  logic       busy_q, sck_q, done_q;
  logic [7:0] tx_sr_q, rx_sr_q;
  logic [2:0] bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      bit_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q  <= 1'b1;
        tx_sr_q <= tx_i;
        bit_q   <= '0;
      end else if (busy_q && tick_i) begin
        if (!sck_q) begin
          sck_q   <= 1'b1;
          rx_sr_q <= {rx_sr_q[6:0], miso_i};
        end else begin
          sck_q <= 1'b0;
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q   <= bit_q + 3'd1;
            tx_sr_q <= {tx_sr_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = tx_sr_q[7];
  assign done_o = done_q;
  assign rx_o   = rx_sr_q;

  assert_sck_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q);

  assert_mosi_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_q && $past(sck_q)) |-> $stable(tx_sr_q[7]));

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter  int BUF_BYTES = 64,
  parameter  int GAP_TICKS = 5,
  localparam int BIDX_W    = $clog2(BUF_BYTES),
  localparam int CNT_W     = BIDX_W + 1,
  localparam int GAP_W     = $clog2(GAP_TICKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [2:0]        sel_i,
  input  logic              pre_en_i,
  input  logic              pre_sel_i,
  input  logic              data_en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [63:0]       menu_i,
  input  logic [15:0]       types_i,
  input  logic [15:0]       prefix_i,
  input  logic [23:0]       addr_i,
  input  logic              tick_i,
  input  logic              sh_done_i,
  input  logic [7:0]        sh_rx_i,
  input  logic [7:0]        buf_rd_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic              rej_o,
  output logic              cs_no,
  output logic              sh_start_o,
  output logic [7:0]        sh_tx_o,
  output logic [BIDX_W-1:0] buf_idx_o,
  output logic              buf_we_o,
  output logic [7:0]        buf_wd_o
);

  seq_state_e        state_q;
  op_type_e          ty_q;
  logic [7:0]        op_q, pre_q;
  logic [23:0]       addr_q;
  logic              den_q, cs_n_q, issue_q, fin_q, rej_q;
  logic [BIDX_W-1:0] last_q, k_q;
  logic [1:0]        ab_q;
  logic [GAP_W-1:0]  gap_q;
  logic              too_long, accept, reject;

  assign too_long = data_en_i && (cnt_i >= CNT_W'(BUF_BYTES));
  assign busy_o   = (state_q != ST_IDLE) || fin_q;
  assign accept   = go_i && !busy_o && !too_long;
  assign reject   = go_i && (busy_o || too_long);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ty_q    <= TY_RD;
      op_q    <= '0;
      pre_q   <= '0;
      addr_q  <= '0;
      den_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      issue_q <= 1'b0;
      fin_q   <= 1'b0;
      rej_q   <= 1'b0;
      last_q  <= '0;
      k_q     <= '0;
      ab_q    <= '0;
      gap_q   <= '0;
    end else begin
      issue_q <= 1'b0;
      fin_q   <= 1'b0;
      rej_q   <= reject;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          op_q    <= menu_i[{sel_i, 3'b000} +: 8];
          ty_q    <= op_type_e'(types_i[{sel_i, 1'b0} +: 2]);
          pre_q   <= pre_sel_i ? prefix_i[15:8] : prefix_i[7:0];
          addr_q  <= addr_i;
          den_q   <= data_en_i;
          last_q  <= cnt_i[BIDX_W-1:0];
          cs_n_q  <= 1'b0;
          issue_q <= 1'b1;
          state_q <= pre_en_i ? ST_PRE : ST_CMD;
        end
        ST_PRE: if (sh_done_i) begin
          cs_n_q  <= 1'b1;
          gap_q   <= '0;
          state_q <= ST_GAP;
        end
        ST_GAP: if (tick_i) begin
          if (gap_q == GAP_W'(GAP_TICKS - 1)) begin
            cs_n_q  <= 1'b0;
            issue_q <= 1'b1;
            state_q <= ST_CMD;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_CMD: if (sh_done_i) begin
          if (ty_q[1]) begin
            ab_q    <= '0;
            issue_q <= 1'b1;
            state_q <= ST_ADR;
          end else if (den_q) begin
            k_q     <= '0;
            issue_q <= 1'b1;
            state_q <= ST_DAT;
          end else begin
            cs_n_q  <= 1'b1;
            fin_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_ADR: if (sh_done_i) begin
          if (ab_q != 2'd2) begin
            ab_q    <= ab_q + 2'd1;
            issue_q <= 1'b1;
          end else if (den_q) begin
            k_q     <= '0;
            issue_q <= 1'b1;
            state_q <= ST_DAT;
          end else begin
            cs_n_q  <= 1'b1;
            fin_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_DAT: if (sh_done_i) begin
          if (k_q == last_q) begin
            cs_n_q  <= 1'b1;
            fin_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            k_q     <= k_q + 1'b1;
            issue_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    sh_tx_o = 8'h00;
    unique case (state_q)
      ST_PRE: sh_tx_o = pre_q;
      ST_CMD: sh_tx_o = op_q;
      ST_ADR: sh_tx_o = (ab_q == 2'd0) ? addr_q[23:16] :
                        (ab_q == 2'd1) ? addr_q[15:8]  : addr_q[7:0];
      ST_DAT: sh_tx_o = ty_q[0] ? buf_rd_i : 8'h00;
      default: sh_tx_o = 8'h00;
    endcase
  end

  assign sh_start_o = issue_q;
  assign cs_no      = cs_n_q;
  assign fin_o      = fin_q;
  assign rej_o      = rej_q;
  assign buf_idx_o  = k_q;
  assign buf_we_o   = (state_q == ST_DAT) && sh_done_i && !ty_q[0];
  assign buf_wd_o   = sh_rx_i;

  assert_start_in_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_start_o |-> !cs_no);

  assert_gap_cs_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |-> cs_no);

  assert_data_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DAT) |-> (k_q <= last_q));

  assert_busy_reject_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && busy_o) |=> rej_o);

  assert_overflow_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && !busy_o && too_long) |=> (cs_no && state_q == ST_IDLE));

endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
  import flash_seq_pkg::*;
#(
  parameter  int DIV_HALF  = 2,
  parameter  int BUF_BYTES = 64,
  localparam int BUF_WORDS = BUF_BYTES / 4,
  localparam int WIDX_W    = (BUF_WORDS > 8) ? $clog2(BUF_WORDS) : 3,
  localparam int REG_AW    = WIDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              spi_sck_o,
  output logic              spi_cs_no,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i
);

  localparam int BIDX_W = $clog2(BUF_BYTES);
  localparam int CNT_W  = BIDX_W + 1;

  logic [63:0]       menu_q;
  logic [15:0]       types_q, prefix_q;
  logic [23:0]       addr_q;
  logic              done_q, err_q;
  logic [7:0]        buf_q [BUF_BYTES];

  logic [WIDX_W-1:0] ridx;
  logic [2:0]        ctl_sel;
  logic              ctl_hit, dw_hit, ctl_we, stat_we, go;
  logic              busy, fin, rej, tick, sh_start, sh_done;
  logic [7:0]        sh_tx, sh_rx, buf_rd, buf_wd;
  logic [BIDX_W-1:0] buf_idx;
  logic              buf_we;

  assign ridx    = reg_addr_i[WIDX_W-1:0];
  assign ctl_sel = ridx[2:0];
  assign ctl_hit = !reg_addr_i[REG_AW-1] && ((ridx >> 3) == '0);
  assign dw_hit  = reg_addr_i[REG_AW-1] && ((ridx >> (BIDX_W - 2)) == '0);
  assign ctl_we  = reg_we_i && ctl_hit;
  assign stat_we = ctl_we && (ctl_sel == RG_STATUS);
  assign go      = ctl_we && (ctl_sel == RG_CTRL) && reg_wdata_i[CB_GO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      menu_q   <= '0;
      types_q  <= '0;
      prefix_q <= '0;
      addr_q   <= '0;
    end else if (ctl_we) begin
      unique case (ctl_sel)
        RG_MENU_LO: menu_q[31:0]  <= reg_wdata_i;
        RG_MENU_HI: menu_q[63:32] <= reg_wdata_i;
        RG_TYPES:   types_q       <= reg_wdata_i[15:0];
        RG_PREFIX:  prefix_q      <= reg_wdata_i[15:0];
        RG_ADDR:    addr_q        <= reg_wdata_i[23:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (fin || rej)                          done_q <= 1'b1;
      else if (stat_we && reg_wdata_i[SB_DONE]) done_q <= 1'b0;
      if (rej)                                 err_q  <= 1'b1;
      else if (stat_we && reg_wdata_i[SB_ERR])  err_q  <= 1'b0;
    end
  end

  // engine capture wins over a same-cycle register write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BUF_BYTES; i++) buf_q[i] <= '0;
    end else begin
      if (reg_we_i && dw_hit)
        for (int j = 0; j < 4; j++)
          buf_q[{ridx[BIDX_W-3:0], 2'(j)}] <= reg_wdata_i[8*j +: 8];
      if (buf_we) buf_q[buf_idx] <= buf_wd;
    end
  end

  assign buf_rd = buf_q[buf_idx];

  always_comb begin
    reg_rdata_o = '0;
    if (dw_hit) begin
      for (int j = 0; j < 4; j++)
        reg_rdata_o[8*j +: 8] = buf_q[{ridx[BIDX_W-3:0], 2'(j)}];
    end else if (ctl_hit) begin
      unique case (ctl_sel)
        RG_MENU_LO: reg_rdata_o = menu_q[31:0];
        RG_MENU_HI: reg_rdata_o = menu_q[63:32];
        RG_TYPES:   reg_rdata_o = {16'h0, types_q};
        RG_PREFIX:  reg_rdata_o = {16'h0, prefix_q};
        RG_ADDR:    reg_rdata_o = {8'h0, addr_q};
        RG_STATUS:  begin
          reg_rdata_o[SB_BUSY] = busy;
          reg_rdata_o[SB_DONE] = done_q;
          reg_rdata_o[SB_ERR]  = err_q;
        end
        default: reg_rdata_o = '0;
      endcase
    end
  end

  flash_seq_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy),
    .tick_o (tick)
  );

  flash_seq_shift u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .start_i (sh_start),
    .tx_i    (sh_tx),
    .miso_i  (spi_miso_i),
    .sck_o   (spi_sck_o),
    .mosi_o  (spi_mosi_o),
    .done_o  (sh_done),
    .rx_o    (sh_rx)
  );

  flash_seq_ctrl #(.BUF_BYTES(BUF_BYTES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go),
    .sel_i      (reg_wdata_i[2:0]),
    .pre_en_i   (reg_wdata_i[CB_PRE_EN]),
    .pre_sel_i  (reg_wdata_i[CB_PRE_SEL]),
    .data_en_i  (reg_wdata_i[CB_DATA_EN]),
    .cnt_i      (reg_wdata_i[CB_CNT_LSB +: CNT_W]),
    .menu_i     (menu_q),
    .types_i    (types_q),
    .prefix_i   (prefix_q),
    .addr_i     (addr_q),
    .tick_i     (tick),
    .sh_done_i  (sh_done),
    .sh_rx_i    (sh_rx),
    .buf_rd_i   (buf_rd),
    .busy_o     (busy),
    .fin_o      (fin),
    .rej_o      (rej),
    .cs_no      (spi_cs_no),
    .sh_start_o (sh_start),
    .sh_tx_o    (sh_tx),
    .buf_idx_o  (buf_idx),
    .buf_we_o   (buf_we),
    .buf_wd_o   (buf_wd)
  );

  assert_err_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> done_q);

  assert_done_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we && reg_wdata_i[SB_DONE] && !fin && !rej) |=> !done_q);

  assert_reset_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (spi_cs_no && !spi_sck_o));

endmodule

// File: tb/sim_flash_seq_top.sv
module sim_flash_seq_top;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_HALF   = 2;
  localparam int BUF_BYTES  = 64;
  localparam int AW         = 5;

  localparam int A_MLO = 0, A_MHI = 1, A_TYP = 2, A_PRE = 3, A_ADR = 4,
                 A_CTL = 5, A_STA = 6, A_DAT = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          sck, cs_n, mosi, miso;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] menu_op [8] = '{8'h02, 8'h03, 8'hD8, 8'h05, 8'hAB, 8'h01, 8'h9F, 8'hC7};
  int         menu_ty [8] = '{3, 2, 3, 0, 2, 1, 0, 1};

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_seq_top #(.DIV_HALF(DIV_HALF), .BUF_BYTES(BUF_BYTES)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .spi_sck_o(sck),
    .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  // flash-side monitor and responder
  logic [7:0] lb [0:1023];
  int         lf [0:1023];
  int         ln = 0, fcnt = 0, bitc = 0, fb = 0;
  logic [7:0] sr = '0;
  realtime    t_rise = 0, last_gap = 0, last_sck = 0, sck_per = 0;

  function automatic logic [7:0] resp(int p);
    return 8'(8'hC3 ^ (p * 29));
  endfunction

  function automatic logic resp_bit(int p, int b);
    logic [7:0] v;
    v = resp(p);
    return v[7 - b];
  endfunction

  assign miso = cs_n ? 1'b0 : resp_bit(fb, bitc);

  always @(negedge cs_n or posedge sck) begin
    if (!cs_n && sck) begin
      if (bitc != 0) sck_per = $realtime - last_sck;
      last_sck = $realtime;
      sr = {sr[6:0], mosi};
      bitc++;
      if (bitc == 8) begin
        lb[ln] = sr; lf[ln] = fcnt; ln++;
        bitc = 0; fb++;
      end
    end else if (!cs_n) begin
      fcnt++; bitc = 0; fb = 0;
      last_gap = $realtime - t_rise;
    end
  end

  always @(posedge cs_n) t_rise = $realtime;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(int a, logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_read(int a, output logic [31:0] d);
    @(negedge clk);
    addr = AW'(a);
    #1 d = rdata;
  endtask

  function automatic logic [31:0] cw(int idx, bit pe, bit ps, bit de, int cnt);
    logic [31:0] w;
    w = '0;
    w[2:0] = idx[2:0]; w[4] = pe; w[5] = ps; w[6] = de; w[7] = 1'b1;
    w[14:8] = cnt[6:0];
    return w;
  endfunction

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      reg_read(A_STA, s);
      if (!s[0]) break;
    end
  endtask

  task automatic setup();
    logic [31:0] lo, hi, ty;
    lo = '0; hi = '0; ty = '0;
    for (int n = 0; n < 4; n++) begin
      lo[8*n +: 8] = menu_op[n];
      hi[8*n +: 8] = menu_op[n+4];
    end
    for (int n = 0; n < 8; n++) ty[2*n +: 2] = 2'(menu_ty[n]);
    reg_write(A_MLO, lo);
    reg_write(A_MHI, hi);
    reg_write(A_TYP, ty);
    reg_write(A_PRE, 32'h0000_5006);
  endtask

  task automatic t_reset();
    logic [31:0] s;
    reg_read(A_STA, s);
    check("R11 status", s, 0);
    check("R11 cs_n", 32'(cs_n), 1);
    check("R11 sck", 32'(sck), 0);
  endtask

  task automatic t_menu();
    int m, f;
    reg_write(A_ADR, 32'h0012_3456);
    for (int n = 0; n < 8; n++) begin
      m = ln; f = fcnt;
      reg_write(A_CTL, cw(n, 0, 0, 0, 0));
      wait_idle();
      check("R1 opcode", 32'(lb[m]), 32'(menu_op[n]));
      check("R1 frames", 32'(fcnt - f), 1);
      if (menu_ty[n] >= 2) begin
        check("R2 len addr", 32'(ln - m), 4);
        check("R2 a_hi", 32'(lb[m+1]), 32'h12);
        check("R2 a_mid", 32'(lb[m+2]), 32'h34);
        check("R2 a_lo", 32'(lb[m+3]), 32'h56);
      end else begin
        check("R2 len noaddr", 32'(ln - m), 1);
      end
    end
  endtask

  task automatic t_prefix_write();
    int m, f;
    logic [7:0] e0 [9] = '{8'h02, 8'hAB, 8'hCD, 8'hEF, 8'h10, 8'h11, 8'h12, 8'h13, 8'h14};
    reg_write(A_DAT,     32'h1312_1110);
    reg_write(A_DAT + 1, 32'h1716_1514);
    reg_write(A_ADR,     32'h00AB_CDEF);
    m = ln; f = fcnt;
    reg_write(A_CTL, cw(0, 1, 0, 1, 4));
    wait_idle();
    check("R3 frames", 32'(fcnt - f), 2);
    check("R3 prefix0", 32'(lb[m]), 32'h06);
    check("R3 prefix own frame", 32'(lf[m+1] - lf[m]), 1);
    check("R3 gap", 32'(last_gap >= 4.0 * DIV_HALF * CLK_PERIOD), 1);
    check("R4 len", 32'(ln - m), 10);
    for (int i = 0; i < 9; i++) check("R4 byte", 32'(lb[m+1+i]), 32'(e0[i]));
    m = ln; f = fcnt;
    reg_write(A_CTL, cw(5, 1, 1, 1, 1));
    wait_idle();
    check("R3 frames p1", 32'(fcnt - f), 2);
    check("R3 prefix1", 32'(lb[m]), 32'h50);
    check("R4 op", 32'(lb[m+1]), 32'h01);
    check("R4 d0", 32'(lb[m+2]), 32'h10);
    check("R4 d1", 32'(lb[m+3]), 32'h11);
    check("R4 len p1", 32'(ln - m), 4);
  endtask

  task automatic t_read();
    int m;
    logic [31:0] w;
    reg_write(A_DAT + 1, 32'hEEEE_EEEE);
    reg_write(A_ADR, 32'h0000_0100);
    m = ln;
    reg_write(A_CTL, cw(1, 0, 0, 1, 5));
    wait_idle();
    check("R5 len", 32'(ln - m), 10);
    check("R5 op", 32'(lb[m]), 32'h03);
    for (int i = 4; i < 10; i++) check("R5 mosi zero", 32'(lb[m+i]), 0);
    reg_read(A_DAT, w);
    check("R5 word0", w, {resp(7), resp(6), resp(5), resp(4)});
    reg_read(A_DAT + 1, w);
    check("R5 word1 tail kept", w, {8'hEE, 8'hEE, resp(9), resp(8)});
  endtask

  task automatic t_nodata();
    int m;
    m = ln;
    reg_write(A_CTL, cw(3, 0, 0, 0, 5));
    wait_idle();
    check("R6 len type0", 32'(ln - m), 1);
    m = ln;
    reg_write(A_CTL, cw(0, 0, 0, 0, 9));
    wait_idle();
    check("R6 len type3", 32'(ln - m), 4);
  endtask

  task automatic t_status();
    logic [31:0] s;
    int m;
    reg_write(A_STA, 32'h6);
    reg_read(A_STA, s);
    check("R7 cleared", s, 0);
    m = ln;
    reg_write(A_CTL, cw(1, 0, 0, 1, 63));
    reg_read(A_STA, s);
    check("R7 busy", s, 32'h1);
    wait_idle();
    reg_read(A_STA, s);
    check("R7 done", s, 32'h2);
    check("R7 max count len", 32'(ln - m), 68);
    reg_write(A_STA, 32'h2);
    reg_read(A_STA, s);
    check("R7 w1c", s, 0);
  endtask

  task automatic t_busy_go();
    logic [31:0] s;
    int m, f;
    reg_write(A_STA, 32'h6);
    m = ln; f = fcnt;
    reg_write(A_CTL, cw(1, 0, 0, 1, 7));
    repeat (6) @(negedge clk);
    reg_write(A_CTL, cw(6, 0, 0, 0, 0));
    repeat (2) @(negedge clk);
    reg_read(A_STA, s);
    check("R8 err while busy", s, 32'h7);
    wait_idle();
    check("R8 one frame", 32'(fcnt - f), 1);
    check("R8 first cmd kept", 32'(lb[m]), 32'h03);
    check("R8 len", 32'(ln - m), 12);
    reg_write(A_STA, 32'h4);
    reg_read(A_STA, s);
    check("R7 err w1c", s, 32'h2);
  endtask

  task automatic t_overflow();
    logic [31:0] s;
    int f;
    reg_write(A_STA, 32'h6);
    f = fcnt;
    reg_write(A_CTL, cw(1, 0, 0, 1, BUF_BYTES));
    repeat (4) @(negedge clk);
    reg_read(A_STA, s);
    check("R9 err done", s, 32'h6);
    check("R9 no frame", 32'(fcnt - f), 0);
    check("R9 cs high", 32'(cs_n), 1);
  endtask

  task automatic t_timing();
    check("R10 sck period", 32'(sck_per == 2.0 * DIV_HALF * CLK_PERIOD), 1);
    check("R10 sck idle", 32'(sck), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    setup();
    t_menu();
    t_prefix_write();
    t_read();
    t_nodata();
    t_status();
    t_busy_go();
    t_overflow();
    t_timing();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule